// File: doc/BRIEF.md
# Oversampling ADC Result Accumulator with Output Justification

This block sits behind a successive-approximation converter and handles its 10-bit output codes. It adds a selectable number of codes into a 16-bit sum, so oversampling and averaging happen without any software. When the last code of a sequence arrives, the block formats the result into a 16-bit word and drives that word as a high byte and a low byte. It pulses a completion flag in the same cycle.

The converter is modelled as a stream of codes. Each code comes with a one-cycle valid strobe, and idle cycles between codes are allowed. A 3-bit repeat select sets the sequence length. A 3-bit format select sets where the result sits in the word: a single code can be placed at the bottom or at the top, and a sum can be divided down by 1, 2, 4 or 8. A clear input throws away a sequence that is only partly done.

Top module: `adc_oversample_acc`

## Requirements
- R1: Codes are 10-bit unsigned values (0 to 1023). With a sequence length of 1 and format bit 2 low, the 16-bit result equals the code and bits 15..10 are zero.
- R2: The repeat select sets the sequence length: 3'b000 gives 1, 3'b001 gives 4, 3'b010 gives 8, 3'b011 gives 16, 3'b100 gives 32, and 3'b101 to 3'b111 give 1.
- R3: For a length above 1, the 16-bit sum of the codes is exact. The largest case, 32 x 1023 = 32736, does not overflow.
- R4: For a length above 1, the result is the sum shifted right by format bits 1..0 (a shift of 0 to 3). Format bit 2 has no effect.
- R5: With a length of 1 and format bit 2 high, the result is the code shifted left by 6, so bits 5..0 are zero.
- R6: The completion flag is high for exactly the one cycle after the clock edge that accepts the final code. The result changes in that same cycle and holds its value in every other cycle.
- R7: Each new sequence starts from zero. Codes from earlier sequences, or from a cleared sequence, are not added in.
- R8: The repeat select is captured with the first code of a sequence. Changing it while the sequence is in progress has no effect.
- R9: The format select is used only with the final code of a sequence. Its value during earlier codes has no effect.
- R10: Clear abandons the sequence in progress. A code strobed in the same cycle as clear is dropped, no completion flag follows, and the held result does not change.
- R11: After a synchronous reset, the result is 0 and the completion flag is low.
- R12: Cycles with the valid strobe low do not count toward the sequence length.
- R13: The result high byte carries bits 15..8 and the low byte carries bits 7..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Abandon the current sequence |
| smp_vld | input | 1 | Strobe: a conversion code is present |
| smp_code | input | 10 | Conversion code |
| rpt_sel | input | 3 | Sequence length select |
| fmt_sel | input | 3 | Justification / averaging shift select |
| res_hi | output | 8 | Result bits 15..8 |
| res_lo | output | 8 | Result bits 7..0 |
| done | output | 1 | One-cycle completion flag |

## Verification
The bench builds the block with its default parameters: 10-bit codes, a 16-bit accumulator and five length modes. At that size every pairing of the eight repeat encodings with the eight format encodings can be run. Each pairing is run under four code patterns, including all-1023 sequences, which reach the largest possible sum. Inside each sequence, the repeat and format selects are changed and idle gaps are added, so the capture rules are exercised. A clear that cuts a sequence short is followed by a full sequence, which shows that nothing was carried over.

// File: rtl/adcacc_pkg.sv
package adcacc_pkg;

  // Sequence length for a repeat select value.
  // Select 0 and any value at or above n_modes give a length of 1.
  // Other values give 2^(sel+1).
  function automatic int unsigned rpt_len(input int unsigned sel,
                                          input int unsigned n_modes);
    if (sel == 0 || sel >= n_modes) return 1;
    return 32'd1 << (sel + 1);
  endfunction

endpackage

// File: rtl/adcacc_seq.sv
module adcacc_seq
  import adcacc_pkg::*;
#(
  parameter int CODE_W  = 10,
  parameter int ACC_W   = 16,
  parameter int SEL_W   = 3,
  parameter int N_MODES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              smp_vld,
  input  logic [CODE_W-1:0] smp_code,
  input  logic [SEL_W-1:0]  rpt_sel,
  output logic              first_o,
  output logic              last_o,
  output logic              single_o,
  output logic [ACC_W-1:0]  sum_o
);
  localparam int MAX_LEN = 1 << N_MODES;
  localparam int IDX_W   = $clog2(MAX_LEN);
  localparam int N_SEL   = 1 << SEL_W;

  logic [IDX_W-1:0] len_tab [N_SEL];
  logic [IDX_W-1:0] idx_q, lastidx_q, lastidx_d;
  logic [ACC_W-1:0] acc_q;
  logic             accept;

  // Final index for each select value, built from the length function.
  for (genvar g = 0; g < N_SEL; g++) begin : g_len
    assign len_tab[g] = IDX_W'(rpt_len(g, N_MODES) - 1);
  end

  assign accept    = smp_vld & ~clr;
  assign first_o   = (idx_q == '0);
  assign lastidx_d = first_o ? len_tab[rpt_sel] : lastidx_q;
  assign last_o    = accept & (idx_q == lastidx_d);
  assign single_o  = (lastidx_d == '0);
  assign sum_o     = first_o ? ACC_W'(smp_code) : acc_q + ACC_W'(smp_code);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx_q     <= '0;
      lastidx_q <= '0;
      acc_q     <= '0;
    end else if (accept) begin
      acc_q <= sum_o;
      if (first_o) lastidx_q <= lastidx_d;
      if (last_o) idx_q <= '0;
      else        idx_q <= idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/adcacc_fmt.sv
module adcacc_fmt #(
  parameter int CODE_W = 10,
  parameter int ACC_W  = 16,
  parameter int SEL_W  = 3,
  parameter int SH_W   = 2
) (
  input  logic [ACC_W-1:0] sum_i,
  input  logic             single_i,
  input  logic [SEL_W-1:0] fmt_sel,
  output logic [ACC_W-1:0] res_o
);
  localparam int LSH  = ACC_W - CODE_W;
  localparam int N_SH = 1 << SH_W;

  logic [ACC_W-1:0] shv [N_SH];

  // One candidate per averaging shift.
  for (genvar g = 0; g < N_SH; g++) begin : g_shift
    assign shv[g] = sum_i >> g;
  end

  always_comb begin
    if (single_i) res_o = fmt_sel[SEL_W-1] ? (sum_i << LSH) : sum_i;
    else          res_o = shv[fmt_sel[SH_W-1:0]];
  end

endmodule

// File: rtl/adcacc_oreg.sv
module adcacc_oreg #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ACC_W-1:0] res_i,
  output logic             done_o,
  output logic [ACC_W-1:0] res_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= 1'b0;
      res_q  <= '0;
    end else begin
      done_o <= load;
      if (load) res_q <= res_i;
    end
  end
endmodule

// File: rtl/adc_oversample_acc.sv
module adc_oversample_acc #(
  parameter int CODE_W  = 10,
  parameter int ACC_W   = 16,
  parameter int SEL_W   = 3,
  parameter int N_MODES = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               smp_vld,
  input  logic [CODE_W-1:0]  smp_code,
  input  logic [SEL_W-1:0]   rpt_sel,
  input  logic [SEL_W-1:0]   fmt_sel,
  output logic [ACC_W/2-1:0] res_hi,
  output logic [ACC_W/2-1:0] res_lo,
  output logic               done
);
  localparam int HALF = ACC_W / 2;

  logic             seq_first, seq_last, seq_single;
  logic [ACC_W-1:0] seq_sum, fmt_res, res_q;

  adcacc_seq #(
    .CODE_W(CODE_W), .ACC_W(ACC_W), .SEL_W(SEL_W), .N_MODES(N_MODES)
  ) u_seq (
    .clk(clk), .rst(rst), .clr(clr), .smp_vld(smp_vld), .smp_code(smp_code),
    .rpt_sel(rpt_sel), .first_o(seq_first), .last_o(seq_last),
    .single_o(seq_single), .sum_o(seq_sum)
  );

  adcacc_fmt #(
    .CODE_W(CODE_W), .ACC_W(ACC_W), .SEL_W(SEL_W), .SH_W(2)
  ) u_fmt (
    .sum_i(seq_sum), .single_i(seq_single), .fmt_sel(fmt_sel), .res_o(fmt_res)
  );

  adcacc_oreg #(.ACC_W(ACC_W)) u_oreg (
    .clk(clk), .rst(rst), .load(seq_last), .res_i(fmt_res),
    .done_o(done), .res_q(res_q)
  );

  assign res_hi = res_q[ACC_W-1:HALF];
  assign res_lo = res_q[HALF-1:0];

endmodule

// File: rtl/adcacc_chk.sv
module adcacc_chk #(
  parameter int CODE_W  = 10,
  parameter int ACC_W   = 16,
  parameter int SEL_W   = 3,
  parameter int N_MODES = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               clr,
  input logic               smp_vld,
  input logic [SEL_W-1:0]   rpt_sel,
  input logic [SEL_W-1:0]   fmt_sel,
  input logic               seq_first,
  input logic [ACC_W/2-1:0] res_hi,
  input logic [ACC_W/2-1:0] res_lo,
  input logic               done
);
  localparam int LSH = ACC_W - CODE_W;

  logic [ACC_W-1:0] res;
  logic             one_len;
  assign res     = {res_hi, res_lo};
  assign one_len = (rpt_sel == '0) || (int'(rpt_sel) >= N_MODES);

  // R6: a completion only follows an accepted code
  p_done_cause_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(smp_vld && !clr));

  // R6: the result changes only together with the completion flag
  p_res_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(res));

  // R10: no completion right after a clear
  p_clr_no_done_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> !done);

  // R1: a single right-justified code has clear upper bits
  p_right_single_r1: assert property (@(posedge clk) disable iff (rst)
    done && $past(seq_first && smp_vld && !clr && one_len && !fmt_sel[SEL_W-1])
    |-> (res >> CODE_W) == '0);

  // R5: a single left-justified code has clear lower bits
  p_left_single_r5: assert property (@(posedge clk) disable iff (rst)
    done && $past(seq_first && smp_vld && !clr && one_len && fmt_sel[SEL_W-1])
    |-> res[LSH-1:0] == '0);

  // R11: reset clears the outputs
  p_reset_r11: assert property (@(posedge clk)
    rst |=> (!done && res == '0));

endmodule

bind adc_oversample_acc adcacc_chk #(
  .CODE_W(CODE_W), .ACC_W(ACC_W), .SEL_W(SEL_W), .N_MODES(N_MODES)
) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .smp_vld(smp_vld), .rpt_sel(rpt_sel),
  .fmt_sel(fmt_sel), .seq_first(seq_first), .res_hi(res_hi),
  .res_lo(res_lo), .done(done)
);

// File: tb/sim_adc_oversample_acc.sv
module sim_adc_oversample_acc;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0;
  logic       smp_vld = 1'b0;
  logic [9:0] smp_code = '0;
  logic [2:0] rpt_sel = '0;
  logic [2:0] fmt_sel = '0;
  logic [7:0] res_hi, res_lo;
  logic       done;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;
  logic [15:0] held = '0;

  always #2 clk = ~clk;

  adc_oversample_acc u0 (
    .clk(clk), .rst(rst), .clr(clr), .smp_vld(smp_vld), .smp_code(smp_code),
    .rpt_sel(rpt_sel), .fmt_sel(fmt_sel), .res_hi(res_hi), .res_lo(res_lo),
    .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R2: length decode written from the requirement
  function automatic int len_of(input int sel);
    case (sel)
      1: return 4;
      2: return 8;
      3: return 16;
      4: return 32;
      default: return 1;
    endcase
  endfunction

  function automatic int code_of(input int pat, input int i, input int rs, input int fs);
    case (pat)
      0: return 1023;
      1: return 0;
      2: return (i * 137 + rs * 59 + fs * 11 + 5) % 1024;
      default: return (i % 2 == 1) ? 1023 : (i * 31) % 1024;
    endcase
  endfunction

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  // One full sequence. The selects are changed mid-sequence (R8, R9),
  // and idle gaps are inserted (R12).
  task automatic run_seq(input int rs, input int fs, input int pat, input int gap);
    int n;
    int sum;
    int code;
    int exp;
    n = len_of(rs);
    sum = 0;
    code = 0;
    for (int i = 0; i < n; i++) begin
      code = code_of(pat, i, rs, fs);
      sum += code;
      @(negedge clk);
      smp_vld  = 1'b1;
      smp_code = 10'(code);
      rpt_sel  = (i == 0) ? 3'(rs) : 3'(rs ^ 5);
      fmt_sel  = (i == n - 1) ? 3'(fs) : 3'(~fs);
      @(negedge clk);
      smp_vld = 1'b0;
      if (i < n - 1) begin
        chk("R6 no early done", int'(done), 0);
        for (int k = 0; k < gap; k++) begin
          @(negedge clk);
          rpt_sel = 3'(k + i);
        end
      end
    end
    if (n == 1) exp = ((fs & 4) != 0) ? (code << 6) : code;   // R1 R5
    else        exp = sum >> (fs & 3);                        // R3 R4
    chk("R6 done on final", int'(done), 1);
    chk($sformatf("R13 result rs=%0d fs=%0d pat=%0d", rs, fs, pat),
        int'({res_hi, res_lo}), exp);
    held = 16'(exp);
    @(negedge clk);
    chk("R6 done single cycle", int'(done), 0);
    chk("R6 result held", int'({res_hi, res_lo}), int'(held));
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset result", int'({res_hi, res_lo}), 0);
    chk("R11 reset done", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 idle after reset", int'(done), 0);

    // Sweep every select pairing under four patterns (R1 to R9, R12, R13).
    for (int rs = 0; rs < 8; rs++)
      for (int fs = 0; fs < 8; fs++)
        for (int pat = 0; pat < 4; pat++)
          run_seq(rs, fs, pat, pat);

    // R10: clear in the middle of a sequence, with a code strobed alongside.
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      smp_vld = 1'b1; smp_code = 10'd700; rpt_sel = 3'd2; fmt_sel = 3'd0;
    end
    @(negedge clk);
    clr = 1'b1; smp_vld = 1'b1; smp_code = 10'd500;
    @(negedge clk);
    clr = 1'b0; smp_vld = 1'b0;
    chk("R10 no done after clear", int'(done), 0);
    chk("R10 result kept", int'({res_hi, res_lo}), int'(held));
    // R7: a following full sequence sums only its own codes.
    run_seq(2, 0, 2, 0);
    run_seq(1, 0, 0, 1);

    // R10: clear on its own while idle leaves the outputs as they are.
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R10 idle clear done", int'(done), 0);
    chk("R10 idle clear result", int'({res_hi, res_lo}), int'(held));
    run_seq(0, 4, 0, 0);

    repeat (2) @(negedge clk);
    summary();
  end

endmodule